// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide programming interface of one eight-input interrupt controller. A host reaches it through a one-bit address, a write strobe, a read strobe and a byte of data. On the even address, writes carry either the first word of the initialization sequence or one of two operational command formats. On the odd address, writes carry the remaining initialization words or the interrupt mask. The block turns this traffic into a set of held control outputs and single-cycle action pulses for a separate priority resolver. The control outputs are vector base, automatic end-of-interrupt, rotation on automatic end-of-interrupt, fully nested mode, special mask, pending poll and read select. The action pulses are in-service clear masks, priority-base loads and a controller reset.

The resolver's request and in-service vectors, its highest in-service line and its highest pending request are inputs. Reads return one of these vectors, or the mask, combinationally while the read strobe is high. A poll read returns the pending request and consumes the poll. A separate trigger-mode register has its own write strobe. Only the bits set in a fixed per-instance parameter mask can be written.

Top module: `irqc_cmd_decoder`

## Requirements
- R1: After synchronous reset, every control output, the mask, the trigger-mode register and every pulse are zero. The initialization step is the mask step, and an even-address read returns `res_irr`.
- R2: An even-address write with data bit 4 set starts initialization. In the next cycle `ctl_reset` and `prio_ld` pulse for one cycle, and the following are all cleared: mask, vector base, auto-EOI, fully nested mode, rotation, special mask, poll and read select. `prio_base` becomes 0. Data bit 0 is stored as "fourth word needed", data bit 1 as "single", and the next odd-address write is taken as the vector word.
- R3: An initialization write with data bit 3 set (level-triggered request, unsupported) raises `init_err` for exactly the next cycle.
- R4: The vector word sets `vec_base` to data AND 0xF8. The next step is as follows: the mode word if single and fourth word needed; the mask if single without the fourth word; otherwise the cascade word. After the cascade word, the next step is the mode word if the fourth word is needed, else the mask.
- R5: The mode word loads `nest_full` from data bit 4 and `auto_eoi` from data bit 1, then returns to the mask step.
- R6: An odd-address write in the mask step loads `imr`. No other write changes `imr` except initialization, which clears it.
- R7: An even-address write with bit 4 clear and bit 3 set is a read command. Bit 2 set makes `poll_pend` 1. Bit 1 set loads `sel_isr` from bit 0. Bit 6 set loads `spec_mask` from bit 5. Cleared enable bits leave the matching flag unchanged.
- R8: With `poll_pend` set, an even-address read returns {`res_req_valid`, 0000, `res_req_id`}, and `poll_pend` is 0 in the following cycle.
- R9: Other even-address writes are priority commands with code = data bits 7:5. Codes 0 and 4 set `rot_aeoi` to code bit 2. Code 2 has no effect.
- R10: Code 1 with `res_isr_valid` pulses `isr_clr` = one-hot of `res_isr_id` in the next cycle. Code 5 does the same and also pulses `prio_ld` with `prio_base` = (`res_isr_id`+1) mod 8. With `res_isr_valid` low, neither code pulses anything.
- R11: Code 3 pulses `isr_clr` = one-hot of data bits 2:0. Code 6 pulses `prio_ld` with `prio_base` = (bits 2:0 + 1) mod 8. Code 7 does both in the same cycle.
- R12: While `bus_rd` is high, an odd-address read returns `imr`. An even-address read without poll returns `res_isr` if `sel_isr` is set, else `res_irr`. With `bus_rd` low, `bus_rdata` is 0.
- R13: A `trig_wr` write stores `bus_wdata` AND `TRIG_MASK`. The register is cleared only by `rst`, not by initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register address (0 even, 1 odd) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| trig_wr | input | 1 | Trigger-mode register write strobe |
| trig_mode | output | 8 | Trigger-mode register |
| res_irr | input | 8 | Resolver request vector |
| res_isr | input | 8 | Resolver in-service vector |
| res_isr_valid | input | 1 | Some line is in service |
| res_isr_id | input | 3 | Highest-priority in-service line |
| res_req_valid | input | 1 | A request would be granted |
| res_req_id | input | 3 | Line that would be granted |
| vec_base | output | 8 | Vector base (low three bits zero) |
| auto_eoi | output | 1 | Automatic end-of-interrupt |
| rot_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| nest_full | output | 1 | Fully nested mode |
| spec_mask | output | 1 | Special mask mode |
| poll_pend | output | 1 | Poll armed for next even read |
| sel_isr | output | 1 | Even reads return in-service vector |
| imr | output | 8 | Interrupt mask |
| isr_clr | output | 8 | One-cycle in-service clear mask |
| prio_ld | output | 1 | One-cycle priority-base load |
| prio_base | output | 3 | Lowest-numbered line of top priority |
| ctl_reset | output | 1 | One-cycle resolver reset at initialization |
| init_err | output | 1 | One-cycle unsupported-mode flag |

## Verification
Every held output and every pulse is due in the cycle after the edge that takes the write: one register stage, no more. `bus_rdata` is due in the same cycle as the read strobe. Poll consumption shows up on `poll_pend` one cycle after the read. Stimulus changes 1 ns after a rising edge. A behavioural model advances on the same edge, and every output is compared at the falling edge, so each comparison sees the state after exactly one register stage.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NIRQ = 8;
    localparam int IDW  = $clog2(NIRQ);
    localparam int DW   = 8;
    localparam int VECW = DW - IDW;

    typedef enum logic [1:0] {
        STEP_MASK = 2'd0,
        STEP_VEC  = 2'd1,
        STEP_CASC = 2'd2,
        STEP_MODE = 2'd3
    } init_step_e;

    typedef enum logic [2:0] {
        PC_ROT_OFF   = 3'd0,
        PC_NSPEC     = 3'd1,
        PC_NOP       = 3'd2,
        PC_SPEC      = 3'd3,
        PC_ROT_ON    = 3'd4,
        PC_NSPEC_ROT = 3'd5,
        PC_SET_PRIO  = 3'd6,
        PC_SPEC_ROT  = 3'd7
    } prio_code_e;

    typedef enum logic [1:0] {
        WK_DATA  = 2'd0,
        WK_INIT  = 2'd1,
        WK_RDCMD = 2'd2,
        WK_PRIO  = 2'd3
    } wkind_e;

    typedef struct packed {
        logic need_mode;
        logic single;
    } init_flags_t;

    typedef struct packed {
        logic [VECW-1:0] vec_hi;
        logic            auto_eoi;
        logic            nest_full;
    } mode_cfg_t;

    function automatic logic [NIRQ-1:0] line_bit(input logic [IDW-1:0] id);
        return NIRQ'(1) << id;
    endfunction

    function automatic logic [IDW-1:0] next_line(input logic [IDW-1:0] id);
        return id + IDW'(1);
    endfunction

    function automatic wkind_e classify(input logic addr, input logic [DW-1:0] d);
        if (addr)      return WK_DATA;
        else if (d[4]) return WK_INIT;
        else if (d[3]) return WK_RDCMD;
        else           return WK_PRIO;
    endfunction

endpackage

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] imr,
    output logic [DW-1:0] vec_base,
    output logic          auto_eoi,
    output logic          nest_full,
    output logic          init_err
);
    init_step_e  step;
    init_flags_t flags;
    mode_cfg_t   cfg;
    wkind_e      kind;

    assign kind = classify(addr, wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            step     <= STEP_MASK;
            flags    <= '0;
            cfg      <= '0;
            imr      <= '0;
            init_err <= 1'b0;
        end else begin
            init_err <= 1'b0;
            if (wr_en && kind == WK_INIT) begin
                imr             <= '0;
                cfg             <= '0;
                flags.need_mode <= wdata[0];
                flags.single    <= wdata[1];
                init_err        <= wdata[3];
                step            <= STEP_VEC;
            end else if (wr_en && kind == WK_DATA) begin
                unique case (step)
                    STEP_MASK: imr <= wdata;
                    STEP_VEC: begin
                        cfg.vec_hi <= wdata[DW-1:IDW];
                        if (flags.single)
                            step <= flags.need_mode ? STEP_MODE : STEP_MASK;
                        else
                            step <= STEP_CASC;
                    end
                    STEP_CASC: step <= flags.need_mode ? STEP_MODE : STEP_MASK;
                    STEP_MODE: begin
                        cfg.nest_full <= wdata[4];
                        cfg.auto_eoi  <= wdata[1];
                        step          <= STEP_MASK;
                    end
                    default: step <= STEP_MASK;
                endcase
            end
        end
    end

    assign vec_base  = {cfg.vec_hi, {IDW{1'b0}}};
    assign auto_eoi  = cfg.auto_eoi;
    assign nest_full = cfg.nest_full;

endmodule

// File: rtl/irqc_op_decode.sv
module irqc_op_decode
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            addr,
    input  logic [DW-1:0]   wdata,
    input  logic            poll_take,
    input  logic            res_isr_valid,
    input  logic [IDW-1:0]  res_isr_id,
    output logic            rot_aeoi,
    output logic            spec_mask,
    output logic            poll_pend,
    output logic            sel_isr,
    output logic [NIRQ-1:0] isr_clr,
    output logic            prio_ld,
    output logic [IDW-1:0]  prio_base,
    output logic            ctl_reset
);
    wkind_e     kind;
    prio_code_e code;
    logic [IDW-1:0] arg;

    assign kind = classify(addr, wdata);
    assign code = prio_code_e'(wdata[7:5]);
    assign arg  = wdata[IDW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rot_aeoi  <= 1'b0;
            spec_mask <= 1'b0;
            poll_pend <= 1'b0;
            sel_isr   <= 1'b0;
            isr_clr   <= '0;
            prio_ld   <= 1'b0;
            prio_base <= '0;
            ctl_reset <= 1'b0;
        end else begin
            isr_clr   <= '0;
            prio_ld   <= 1'b0;
            ctl_reset <= 1'b0;
            if (poll_take)
                poll_pend <= 1'b0;
            if (wr_en) begin
                unique case (kind)
                    WK_INIT: begin
                        rot_aeoi  <= 1'b0;
                        spec_mask <= 1'b0;
                        poll_pend <= 1'b0;
                        sel_isr   <= 1'b0;
                        prio_base <= '0;
                        prio_ld   <= 1'b1;
                        ctl_reset <= 1'b1;
                    end
                    WK_RDCMD: begin
                        if (wdata[2]) poll_pend <= 1'b1;
                        if (wdata[1]) sel_isr   <= wdata[0];
                        if (wdata[6]) spec_mask <= wdata[5];
                    end
                    WK_PRIO: begin
                        unique case (code)
                            PC_ROT_OFF, PC_ROT_ON: rot_aeoi <= code[2];
                            PC_NSPEC, PC_NSPEC_ROT: begin
                                if (res_isr_valid) begin
                                    isr_clr <= line_bit(res_isr_id);
                                    if (code == PC_NSPEC_ROT) begin
                                        prio_base <= next_line(res_isr_id);
                                        prio_ld   <= 1'b1;
                                    end
                                end
                            end
                            PC_SPEC: isr_clr <= line_bit(arg);
                            PC_SET_PRIO: begin
                                prio_base <= next_line(arg);
                                prio_ld   <= 1'b1;
                            end
                            PC_SPEC_ROT: begin
                                isr_clr   <= line_bit(arg);
                                prio_base <= next_line(arg);
                                prio_ld   <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/irqc_rd_path.sv
module irqc_rd_path
    import irqc_pkg::*;
(
    input  logic            rd_en,
    input  logic            addr,
    input  logic            poll_pend,
    input  logic            sel_isr,
    input  logic [NIRQ-1:0] res_irr,
    input  logic [NIRQ-1:0] res_isr,
    input  logic [DW-1:0]   imr,
    input  logic            res_req_valid,
    input  logic [IDW-1:0]  res_req_id,
    output logic [DW-1:0]   rdata,
    output logic            poll_take
);
    logic [DW-1:0] poll_word;

    assign poll_word = {res_req_valid, {(DW-1-IDW){1'b0}}, res_req_id};
    assign poll_take = rd_en && !addr && poll_pend;

    always_comb begin
        if (!rd_en)        rdata = '0;
        else if (addr)     rdata = imr;
        else if (poll_pend) rdata = poll_word;
        else if (sel_isr)  rdata = res_isr;
        else               rdata = res_irr;
    end

endmodule

// File: rtl/irqc_trig_reg.sv
module irqc_trig_reg
    import irqc_pkg::*;
#(
    parameter logic [NIRQ-1:0] TRIG_MASK = 8'hF8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [NIRQ-1:0] wdata,
    output logic [NIRQ-1:0] trig_mode
);
    for (genvar i = 0; i < NIRQ; i++) begin : g_bit
        if (TRIG_MASK[i]) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)        trig_mode[i] <= 1'b0;
                else if (wr_en) trig_mode[i] <= wdata[i];
            end
        end else begin : g_ro
            assign trig_mode[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irqc_cmd_decoder.sv
module irqc_cmd_decoder
    import irqc_pkg::*;
#(
    parameter logic [NIRQ-1:0] TRIG_MASK = 8'hF8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            trig_wr,
    output logic [NIRQ-1:0] trig_mode,
    input  logic [NIRQ-1:0] res_irr,
    input  logic [NIRQ-1:0] res_isr,
    input  logic            res_isr_valid,
    input  logic [IDW-1:0]  res_isr_id,
    input  logic            res_req_valid,
    input  logic [IDW-1:0]  res_req_id,
    output logic [DW-1:0]   vec_base,
    output logic            auto_eoi,
    output logic            rot_aeoi,
    output logic            nest_full,
    output logic            spec_mask,
    output logic            poll_pend,
    output logic            sel_isr,
    output logic [DW-1:0]   imr,
    output logic [NIRQ-1:0] isr_clr,
    output logic            prio_ld,
    output logic [IDW-1:0]  prio_base,
    output logic            ctl_reset,
    output logic            init_err
);
    logic poll_take;

    irqc_init_seq u_init (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .imr       (imr),
        .vec_base  (vec_base),
        .auto_eoi  (auto_eoi),
        .nest_full (nest_full),
        .init_err  (init_err)
    );

    irqc_op_decode u_op (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (bus_wr),
        .addr          (bus_addr),
        .wdata         (bus_wdata),
        .poll_take     (poll_take),
        .res_isr_valid (res_isr_valid),
        .res_isr_id    (res_isr_id),
        .rot_aeoi      (rot_aeoi),
        .spec_mask     (spec_mask),
        .poll_pend     (poll_pend),
        .sel_isr       (sel_isr),
        .isr_clr       (isr_clr),
        .prio_ld       (prio_ld),
        .prio_base     (prio_base),
        .ctl_reset     (ctl_reset)
    );

    irqc_rd_path u_rd (
        .rd_en         (bus_rd),
        .addr          (bus_addr),
        .poll_pend     (poll_pend),
        .sel_isr       (sel_isr),
        .res_irr       (res_irr),
        .res_isr       (res_isr),
        .imr           (imr),
        .res_req_valid (res_req_valid),
        .res_req_id    (res_req_id),
        .rdata         (bus_rdata),
        .poll_take     (poll_take)
    );

    irqc_trig_reg #(.TRIG_MASK(TRIG_MASK)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (trig_wr),
        .wdata     (bus_wdata),
        .trig_mode (trig_mode)
    );

endmodule

// File: rtl/irqc_cmd_decoder_chk.sv
module irqc_cmd_decoder_chk
    import irqc_pkg::*;
#(
    parameter logic [NIRQ-1:0] TRIG_MASK = 8'hF8
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_addr,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [DW-1:0]   bus_wdata,
    input logic [NIRQ-1:0] trig_mode,
    input logic [DW-1:0]   imr,
    input logic            auto_eoi,
    input logic            nest_full,
    input logic            poll_pend,
    input logic [NIRQ-1:0] isr_clr,
    input logic            prio_ld,
    input logic            ctl_reset,
    input logic            init_err
);
    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr && bus_wdata[4]) |=> (imr == '0 && !auto_eoi && !nest_full && ctl_reset && prio_ld)); // R2

    AST_LEVEL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr && bus_wdata[4] && bus_wdata[3]) |=> init_err); // R3

    AST_IMR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(imr)); // R6

    AST_POLL_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_addr && !bus_wr) |=> !poll_pend); // R8

    AST_CLEAR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(isr_clr)); // R11

    AST_TRIG_MASKED: assert property (@(posedge clk) disable iff (rst)
        (trig_mode & ~TRIG_MASK) == '0); // R13

endmodule

bind irqc_cmd_decoder irqc_cmd_decoder_chk #(.TRIG_MASK(TRIG_MASK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .trig_mode (trig_mode),
    .imr       (imr),
    .auto_eoi  (auto_eoi),
    .nest_full (nest_full),
    .poll_pend (poll_pend),
    .isr_clr   (isr_clr),
    .prio_ld   (prio_ld),
    .ctl_reset (ctl_reset),
    .init_err  (init_err)
);

// File: tb/irqc_cmd_decoder_bench.sv
module irqc_cmd_decoder_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, trig_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] res_irr = 8'h00, res_isr = 8'h00;
    logic res_isr_valid = 1'b0, res_req_valid = 1'b0;
    logic [2:0] res_isr_id = 3'd0, res_req_id = 3'd0;
    logic [7:0] bus_rdata, trig_mode, vec_base, imr, isr_clr;
    logic auto_eoi, rot_aeoi, nest_full, spec_mask, poll_pend, sel_isr;
    logic prio_ld, ctl_reset, init_err;
    logic [2:0] prio_base;

    int checks = 0;
    int errors = 0;
    bit live = 1'b0;

    always #4 clk = ~clk;

    irqc_cmd_decoder u_irqc_cmd_decoder (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_wr(trig_wr), .trig_mode(trig_mode),
        .res_irr(res_irr), .res_isr(res_isr), .res_isr_valid(res_isr_valid),
        .res_isr_id(res_isr_id), .res_req_valid(res_req_valid), .res_req_id(res_req_id),
        .vec_base(vec_base), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi), .nest_full(nest_full),
        .spec_mask(spec_mask), .poll_pend(poll_pend), .sel_isr(sel_isr), .imr(imr),
        .isr_clr(isr_clr), .prio_ld(prio_ld), .prio_base(prio_base),
        .ctl_reset(ctl_reset), .init_err(init_err)
    );

    // behavioural reference state
    int  m_phase;
    bit  m_four, m_single;
    logic [7:0] m_imr, m_vec, m_trig, m_clr;
    bit  m_aeoi, m_nest, m_rot, m_smask, m_poll, m_sel, m_pld, m_crst, m_err;
    int  m_base;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_four = 0; m_single = 0;
            m_imr = 0; m_vec = 0; m_trig = 0; m_clr = 0;
            m_aeoi = 0; m_nest = 0; m_rot = 0; m_smask = 0; m_poll = 0; m_sel = 0;
            m_pld = 0; m_crst = 0; m_err = 0; m_base = 0;
        end else begin
            m_clr = 0; m_pld = 0; m_crst = 0; m_err = 0;
            if (bus_rd && !bus_addr) m_poll = 0;
            if (trig_wr) m_trig = bus_wdata & 8'hF8;
            if (bus_wr && bus_addr) begin
                if (m_phase == 0) m_imr = bus_wdata;
                else if (m_phase == 1) begin
                    m_vec = bus_wdata & 8'hF8;
                    m_phase = !m_single ? 2 : (m_four ? 3 : 0);
                end else if (m_phase == 2) m_phase = m_four ? 3 : 0;
                else begin
                    m_nest = bus_wdata[4]; m_aeoi = bus_wdata[1]; m_phase = 0;
                end
            end else if (bus_wr && bus_wdata[4]) begin
                m_imr = 0; m_vec = 0; m_aeoi = 0; m_nest = 0; m_rot = 0; m_smask = 0;
                m_poll = 0; m_sel = 0; m_base = 0; m_pld = 1; m_crst = 1;
                m_err = bus_wdata[3]; m_four = bus_wdata[0]; m_single = bus_wdata[1];
                m_phase = 1;
            end else if (bus_wr && bus_wdata[3]) begin
                if (bus_wdata[2]) m_poll = 1;
                if (bus_wdata[1]) m_sel = bus_wdata[0];
                if (bus_wdata[6]) m_smask = bus_wdata[5];
            end else if (bus_wr) begin
                int c, n;
                c = bus_wdata[7:5];
                n = bus_wdata[2:0];
                if (c == 0 || c == 4) m_rot = (c == 4);
                if ((c == 1 || c == 5) && res_isr_valid) begin
                    m_clr = 8'(1 << res_isr_id);
                    if (c == 5) begin m_base = (res_isr_id + 1) % 8; m_pld = 1; end
                end
                if (c == 3 || c == 7) m_clr = 8'(1 << n);
                if (c == 6 || c == 7) begin m_base = (n + 1) % 8; m_pld = 1; end
            end
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata();
        if (!bus_rd) return 8'h00;
        if (bus_addr) return m_imr;
        if (m_poll) return {res_req_valid, 4'b0000, res_req_id};
        return m_sel ? res_isr : res_irr;
    endfunction

    always @(negedge clk) begin
        if (live && !rst) begin
            chk("R2 ctl_reset", {7'd0, ctl_reset}, {7'd0, m_crst});
            chk("R3 init_err", {7'd0, init_err}, {7'd0, m_err});
            chk("R4 vec_base", vec_base, m_vec);
            chk("R5 auto_eoi/nest_full", {6'd0, auto_eoi, nest_full}, {6'd0, m_aeoi, m_nest});
            chk("R6 imr", imr, m_imr);
            chk("R7 spec_mask/sel_isr", {6'd0, spec_mask, sel_isr}, {6'd0, m_smask, m_sel});
            chk("R8 poll_pend", {7'd0, poll_pend}, {7'd0, m_poll});
            chk("R9 rot_aeoi", {7'd0, rot_aeoi}, {7'd0, m_rot});
            chk("R10 R11 isr_clr", isr_clr, m_clr);
            chk("R10 R11 prio", {4'd0, prio_ld, prio_base}, {4'd0, m_pld, 3'(m_base)});
            chk("R12 bus_rdata", bus_rdata, exp_rdata());
            chk("R13 trig_mode", trig_mode, m_trig);
        end
    end

    task automatic cyc(bit a, bit w, bit r, bit t, logic [7:0] d);
        bus_addr = a; bus_wr = w; bus_rd = r; trig_wr = t; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0; bus_rd = 0; trig_wr = 0;
    endtask

    task automatic wr(bit a, logic [7:0] d); cyc(a, 1, 0, 0, d); endtask
    task automatic rd(bit a); cyc(a, 0, 1, 0, 8'h00); endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        live = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 imr", imr, 8'h00);
        chk("R1 ctrl", {auto_eoi, rot_aeoi, nest_full, spec_mask, poll_pend, sel_isr, prio_ld, init_err}, 8'h00);
        chk("R1 trig", trig_mode, 8'h00);
        res_irr = 8'h5A; res_isr = 8'hC3;
        @(posedge clk); #1;
        rd(0);
        // R6 mask write in step 0
        wr(1, 8'hA5);
        rd(1);
        // R13 trigger register masking
        cyc(0, 0, 0, 1, 8'hFF);
        // R2 R4 R5: single + fourth word
        wr(0, 8'h13);
        wr(1, 8'h4F);
        wr(1, 8'h12);
        @(negedge clk);
        chk("R4 vec direct", vec_base, 8'h48);
        chk("R5 mode direct", {6'd0, auto_eoi, nest_full}, 8'h03);
        chk("R13 kept over init", trig_mode, 8'hF8);
        @(posedge clk); #1;
        wr(1, 8'h3C);
        // cascaded, no fourth word: vec, casc, then mask
        wr(0, 8'h10);
        wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h81);
        // cascaded with fourth word
        wr(0, 8'h11);
        wr(1, 8'h70); wr(1, 8'h02); wr(1, 8'h10); wr(1, 8'h0F);
        // single without fourth word, level bit set (R3)
        wr(0, 8'h1A);
        wr(1, 8'h99); wr(1, 8'h66);
        @(negedge clk);
        chk("R6 imr direct", imr, 8'h66);
        @(posedge clk); #1;
        // R7 read commands
        wr(0, 8'h0B); rd(0);
        wr(0, 8'h68); rd(0);
        wr(0, 8'h48); wr(0, 8'h0A); rd(0);
        // R8 poll
        res_req_valid = 1; res_req_id = 3'd5;
        wr(0, 8'h0C); rd(0); rd(0);
        res_req_valid = 0;
        wr(0, 8'h0C); rd(1); rd(0);
        // R9 rotation codes
        wr(0, 8'h80); wr(0, 8'h40); wr(0, 8'h00);
        // R10 nonspecific EOI
        res_isr_valid = 1; res_isr_id = 3'd6;
        wr(0, 8'h20); wr(0, 8'hA0);
        res_isr_id = 3'd7; wr(0, 8'hA0);
        res_isr_valid = 0; wr(0, 8'h20); wr(0, 8'hA0);
        // R11 specific codes
        wr(0, 8'h62); wr(0, 8'hC7); wr(0, 8'hE3); wr(0, 8'hE7);
        for (int i = 0; i < 8; i++) wr(0, 8'(8'h60 | i));
        wr(0, 8'h10);
        repeat (2) @(posedge clk);
        #1 live = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule